// File: doc/BRIEF.md
# UART In-Band Flow Controller

This block runs XON/XOFF software flow control for one UART channel. On the receive side it compares each incoming character with four programmable flow characters. A recognised XOFF stops the local transmitter. A recognised XON, or any character when the resume-on-any option is set, lets it run again. Flow characters are taken out of the data stream. Every other character is marked as data to keep.

On the transmit side it watches the fill level of the receive buffer. When the level reaches a high mark, it asks the serializer to send an XOFF. When the level later drops to a low mark, it asks for an XON. A request waits until the serializer reports a character boundary, and it goes ahead of normal data. The serializer sends normal data only while `tx_hold` is low. The modem lines CTS and DSR also hold the transmitter, and each hold cause has its own status bit.

Top module: `uart_xonxoff_ctrl`

## Requirements
- R1: After reset, `xon_flag` is 1, `ins_valid` is 0, `irq` is 0, and `hold_stat[4:2]` are 0.
- R2: `flow_mode[1:0]` selects the receive mode: 2'b10 uses pair A and 2'b01 uses pair B. A strobed character equal to that pair's XOFF sets `hold_stat[3]` and clears `xon_flag` in the cycle after the strobe. If the character matches both the XON and the XOFF of the pair, it counts as an XOFF.
- R3: In receive mode 2'b10 or 2'b01, a character equal to the selected XON (and not equal to its XOFF) clears `hold_stat[3]` and sets `xon_flag` in the cycle after the strobe.
- R4: In receive mode 2'b11, only the sequence XON-A then XON-B releases the hold, and only the sequence XOFF-A then XOFF-B sets it. Both characters of either sequence have `rx_keep` low.
- R5: In receive mode 2'b11, a character that does not complete the sequence after a first match returns the matcher to idle. That character is kept as data (`rx_keep` high) and leaves the hold unchanged unless R7 applies.
- R6: In receive mode 2'b00 no character is recognised. Every strobed character has `rx_keep` high, and the hold is unchanged while `xon_any` is 0.
- R7: While `xon_any` is 1, any strobed character that does not complete an XOFF clears the XOFF hold in the next cycle.
- R8: With `flow_mode[3:2]` non-zero, no request pending and no XOFF outstanding, `rx_level >= HI_MARK` raises `ins_valid` one cycle later. The character sent is XOFF-A for 2'b10, XOFF-B for 2'b01, and XOFF-A followed by XOFF-B for 2'b11.
- R9: `hold_stat[4]` goes to 1 when the last character of an XOFF request is taken, and back to 0 when the last character of an XON is taken. An XON (same pair rules as R8) is requested only while `hold_stat[4]` is 1 and `rx_level <= LO_MARK`.
- R10: A request stays on `ins_valid`/`ins_chr` until a cycle with `tx_bound` high, and then advances one character per such cycle. The XOFF hold and the modem lines do not block requests. With `flow_mode[3:2]` = 2'b00, `ins_valid` stays 0.
- R11: `hold_stat[0]` is the inverse of `cts_in` and `hold_stat[1]` is the inverse of `dsr_in`. `tx_hold` is high whenever any of `hold_stat[1:0]` or `hold_stat[3]` is set.
- R12: `irq` pulses high for one cycle after a strobe that completes an XON or XOFF recognition while `irq_en` is 1. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_mode | input | 4 | [3:2] transmit mode, [1:0] receive mode |
| on_chr_a | input | CW | XON character, pair A |
| on_chr_b | input | CW | XON character, pair B |
| off_chr_a | input | CW | XOFF character, pair A |
| off_chr_b | input | CW | XOFF character, pair B |
| xon_any | input | 1 | Any received character releases the XOFF hold |
| irq_en | input | 1 | Enables the recognition interrupt |
| rx_stb | input | 1 | A received character is present this cycle |
| rx_data | input | CW | Received character |
| rx_keep | output | 1 | The strobed character is data and is not consumed |
| rx_level | input | LW | Receive buffer fill level |
| cts_in | input | 1 | CTS asserted (high = clear to send) |
| dsr_in | input | 1 | DSR asserted |
| tx_bound | input | 1 | Serializer is at a character boundary and takes `ins_chr` if valid |
| tx_hold | output | 1 | Normal data must not start |
| ins_valid | output | 1 | A flow character is waiting to be sent |
| ins_chr | output | CW | Flow character to send |
| xon_flag | output | 1 | Flow control currently allows transmission |
| hold_stat | output | 5 | Hold causes: 0 CTS low, 1 DSR low, 3 XOFF received, 4 XOFF sent |
| irq | output | 1 | One-cycle recognition interrupt |

## Verification
The bench builds the block with CW=8, LW=5, HI_MARK=12 and LO_MARK=4. The narrow level field and close marks mean the bench reaches both thresholds, and the exact values at each mark, in a few cycles. The four flow characters are distinct. Random receive traffic is drawn mostly from them, so two-character sequences, broken sequences and resume-on-any releases all occur often across mode changes.

// File: rtl/uart_xonxoff_ctrl.sv
module uart_xonxoff_ctrl #(
  parameter int CW      = 8,
  parameter int LW      = 7,
  parameter int HI_MARK = 48,
  parameter int LO_MARK = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    flow_mode,
  input  logic [CW-1:0] on_chr_a,
  input  logic [CW-1:0] on_chr_b,
  input  logic [CW-1:0] off_chr_a,
  input  logic [CW-1:0] off_chr_b,
  input  logic          xon_any,
  input  logic          irq_en,
  input  logic          rx_stb,
  input  logic [CW-1:0] rx_data,
  output logic          rx_keep,
  input  logic [LW-1:0] rx_level,
  input  logic          cts_in,
  input  logic          dsr_in,
  input  logic          tx_bound,
  output logic          tx_hold,
  output logic          ins_valid,
  output logic [CW-1:0] ins_chr,
  output logic          xon_flag,
  output logic [4:0]    hold_stat,
  output logic          irq
);

  localparam logic [1:0]    M_OFF = 2'b00;
  localparam logic [1:0]    M_B   = 2'b01;
  localparam logic [1:0]    M_A   = 2'b10;
  localparam logic [1:0]    M_AB  = 2'b11;
  localparam logic [LW-1:0] HI_L  = LW'(HI_MARK);
  localparam logic [LW-1:0] LO_L  = LW'(LO_MARK);

  typedef enum logic [1:0] {RS_IDLE, RS_ON1, RS_OFF1} rx_st_t;
  typedef enum logic [1:0] {PK_NONE, PK_OFF, PK_ON} pend_t;

  logic [1:0] txm, rxm;
  assign txm = flow_mode[3:2];
  assign rxm = flow_mode[1:0];

  rx_st_t rx_st;
  logic   xoff_hold, xoff_sent, irq_q;
  pend_t  pend;
  logic   pend_2nd;

  // receive recognition
  logic [CW-1:0] on_sel, off_sel;
  logic single, sgl_off, sgl_on;
  logic seq_start_on, seq_start_off, seq_fin_on, seq_fin_off;
  logic got_on, got_off, consumed, any_rel;

  assign on_sel  = (rxm == M_A) ? on_chr_a  : on_chr_b;
  assign off_sel = (rxm == M_A) ? off_chr_a : off_chr_b;
  assign single  = (rxm == M_A) || (rxm == M_B);
  assign sgl_off = single && (rx_data == off_sel);
  assign sgl_on  = single && (rx_data == on_sel) && !sgl_off;

  assign seq_start_on  = (rxm == M_AB) && (rx_st == RS_IDLE) && (rx_data == on_chr_a);
  assign seq_start_off = (rxm == M_AB) && (rx_st == RS_IDLE) && (rx_data == off_chr_a) && !seq_start_on;
  assign seq_fin_on    = (rxm == M_AB) && (rx_st == RS_ON1)  && (rx_data == on_chr_b);
  assign seq_fin_off   = (rxm == M_AB) && (rx_st == RS_OFF1) && (rx_data == off_chr_b);

  assign got_off  = rx_stb && (sgl_off || seq_fin_off);
  assign got_on   = rx_stb && (sgl_on  || seq_fin_on);
  assign consumed = got_on || got_off || (rx_stb && (seq_start_on || seq_start_off));
  assign any_rel  = rx_stb && xon_any && !got_off;
  assign rx_keep  = rx_stb && !consumed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st     <= RS_IDLE;
      xoff_hold <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= irq_en && (got_on || got_off);
      if (got_off)
        xoff_hold <= 1'b1;
      else if (got_on || any_rel)
        xoff_hold <= 1'b0;
      if (rxm != M_AB)
        rx_st <= RS_IDLE;
      else if (rx_stb) begin
        if (seq_start_on)       rx_st <= RS_ON1;
        else if (seq_start_off) rx_st <= RS_OFF1;
        else                    rx_st <= RS_IDLE;
      end
    end
  end

  // transmit insertion
  logic tx_act, a_side, take, last;

  assign tx_act    = (txm != M_OFF);
  assign ins_valid = (pend != PK_NONE) && tx_act;
  assign a_side    = (txm == M_A) || ((txm == M_AB) && !pend_2nd);
  assign ins_chr   = (pend == PK_ON) ? (a_side ? on_chr_a : on_chr_b)
                                     : (a_side ? off_chr_a : off_chr_b);
  assign take      = tx_bound && ins_valid;
  assign last      = (txm != M_AB) || pend_2nd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= PK_NONE;
      pend_2nd  <= 1'b0;
      xoff_sent <= 1'b0;
    end else if (take) begin
      if (last) begin
        pend      <= PK_NONE;
        pend_2nd  <= 1'b0;
        xoff_sent <= (pend == PK_OFF);
      end else begin
        pend_2nd <= 1'b1;
      end
    end else if ((pend == PK_NONE) && tx_act) begin
      if (!xoff_sent && (rx_level >= HI_L))
        pend <= PK_OFF;
      else if (xoff_sent && (rx_level <= LO_L))
        pend <= PK_ON;
    end
  end

  assign hold_stat = {xoff_sent, xoff_hold, 1'b0, !dsr_in, !cts_in};
  assign tx_hold   = xoff_hold || !cts_in || !dsr_in;
  assign xon_flag  = !xoff_hold;
  assign irq       = irq_q;

  p_off_sets_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && rxm == M_A && rx_data == off_chr_a) |=> (hold_stat[3] && !xon_flag));

  p_on_clears_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && rxm == M_B && rx_data == on_chr_b && rx_data != off_chr_b) |=> xon_flag);

  p_idle_mode_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && rxm == M_OFF && !xon_any) |=> $stable(hold_stat[3]));

  p_any_resumes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && xon_any && rxm == M_OFF) |=> xon_flag);

  p_xoff_queued_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && !ins_valid && !hold_stat[4] && rx_level >= HI_L) |=> (ins_valid || flow_mode[3:2] == M_OFF));

  p_sent_needs_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_stat[4]) |-> $past(tx_bound && ins_valid));

  p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_stb && irq_en));

endmodule

// File: tb/uart_xonxoff_ctrl_tb_top.sv
module uart_xonxoff_ctrl_tb_top;
  localparam int CW = 8, LW = 5, HI = 12, LO = 4;
  localparam logic [7:0] ONA = 8'h11, OFFA = 8'h13, ONB = 8'h21, OFFB = 8'h23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] flow_mode = 4'b0;
  logic xon_any = 0, irq_en = 0, rx_stb = 0, cts_in = 1, dsr_in = 1, tx_bound = 0;
  logic [CW-1:0] rx_data = '0;
  logic [LW-1:0] rx_level = '0;
  logic rx_keep, tx_hold, ins_valid, xon_flag, irq;
  logic [CW-1:0] ins_chr;
  logic [4:0] hold_stat;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int m_hold = 0, m_st = 0;

  always #4 clk = ~clk;

  uart_xonxoff_ctrl #(.CW(CW), .LW(LW), .HI_MARK(HI), .LO_MARK(LO)) dut_i (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
    .on_chr_a(ONA), .on_chr_b(ONB), .off_chr_a(OFFA), .off_chr_b(OFFB),
    .xon_any(xon_any), .irq_en(irq_en), .rx_stb(rx_stb), .rx_data(rx_data),
    .rx_keep(rx_keep), .rx_level(rx_level), .cts_in(cts_in), .dsr_in(dsr_in),
    .tx_bound(tx_bound), .tx_hold(tx_hold), .ins_valid(ins_valid), .ins_chr(ins_chr),
    .xon_flag(xon_flag), .hold_stat(hold_stat), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Expected receive behaviour from R2..R7, R12
  task automatic send(input logic [7:0] d, input logic [1:0] rm, input bit xa,
                      input bit ie, input string tag);
    bit on = 0, off = 0, cons = 0;
    int nst = 0;
    flow_mode = {flow_mode[3:2], rm};
    xon_any = xa; irq_en = ie; rx_data = d; rx_stb = 1;
    if (rm == 2'b10 || rm == 2'b01) begin
      off = (d == (rm == 2'b10 ? OFFA : OFFB));
      on  = !off && (d == (rm == 2'b10 ? ONA : ONB));
    end else if (rm == 2'b11) begin
      if (m_st == 0) begin
        if (d == ONA) begin nst = 1; cons = 1; end
        else if (d == OFFA) begin nst = 2; cons = 1; end
      end else if (m_st == 1) on = (d == ONB);
      else off = (d == OFFB);
    end
    cons = cons | on | off;
    #1;
    chk({tag, " rx_keep"}, rx_keep, !cons);
    tick();
    rx_stb = 0;
    m_st = nst;
    if (off) m_hold = 1;
    else if (on || xa) m_hold = 0;
    chk({tag, " hold"}, hold_stat[3], m_hold);
    chk({tag, " xon_flag"}, xon_flag, !m_hold);
    chk({tag, " irq"}, irq, ie && (on || off));
  endtask

  task automatic expect_ins(input string tag, input bit v, input logic [7:0] c);
    chk({tag, " ins_valid"}, ins_valid, v);
    if (v) chk({tag, " ins_chr"}, ins_chr, c);
  endtask

  task automatic take();
    tx_bound = 1; tick(); tx_bound = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd5151);
    repeat (3) tick();
    // R1 reset state
    chk("R1 xon_flag", xon_flag, 1);
    chk("R1 ins_valid", ins_valid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 hold_stat", hold_stat[4:2], 0);
    rst_n = 1; tick();

    // R11 modem lines
    cts_in = 0; #1;
    chk("R11 cts bit", hold_stat[0], 1); chk("R11 tx_hold cts", tx_hold, 1);
    cts_in = 1; dsr_in = 0; #1;
    chk("R11 dsr bit", hold_stat[1], 1); chk("R11 tx_hold dsr", tx_hold, 1);
    dsr_in = 1; #1;
    chk("R11 released", tx_hold, 0);

    // R2/R3 single-character pairs, R12 interrupt
    send(OFFA, 2'b10, 0, 1, "R2 pairA xoff");
    chk("R11 tx_hold xoff", tx_hold, 1);
    send(ONB, 2'b10, 0, 1, "R3 pairB char ignored in A");
    send(ONA, 2'b10, 0, 0, "R3 pairA xon no irq R12");
    send(OFFB, 2'b01, 0, 1, "R2 pairB xoff");
    send(ONB, 2'b01, 0, 1, "R3 pairB xon");
    // R4 two-character sequences
    send(OFFA, 2'b11, 0, 1, "R4 first xoff");
    send(OFFB, 2'b11, 0, 1, "R4 second xoff");
    send(ONB, 2'b11, 0, 1, "R4 lone xonB");
    send(ONA, 2'b11, 0, 1, "R4 first xon");
    // R5 broken sequence
    send(8'h55, 2'b11, 0, 1, "R5 mismatch kept");
    send(ONA, 2'b11, 0, 1, "R5 restart");
    send(ONB, 2'b11, 0, 1, "R5 complete");
    // R6 receive disabled
    send(OFFA, 2'b00, 0, 1, "R6 xoff ignored");
    // R7 any character resumes
    send(OFFA, 2'b10, 0, 0, "R7 set hold");
    send(8'h41, 2'b10, 1, 0, "R7 any char");
    send(OFFA, 2'b10, 1, 0, "R7 xoff still holds");

    // random receive traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      int pick = $urandom_range(0, 5);
      case (pick)
        0: d = ONA; 1: d = OFFA; 2: d = ONB; 3: d = OFFB;
        default: d = 8'($urandom_range(0, 255));
      endcase
      send(d, 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
           1'($urandom_range(0, 1)), "R4 R5 R7 random");
      if ($urandom_range(0, 3) == 0) tick();
    end
    send(ONA, 2'b10, 1, 0, "R7 clear");
    flow_mode = 4'b0; tick();

    // transmit side: pair A
    flow_mode = 4'b1000; rx_level = 5'd3; tick(); tick();
    expect_ins("R9 no xon before xoff", 0, 0);
    rx_level = 5'd11; tick(); tick();
    expect_ins("R8 below high mark", 0, 0);
    rx_level = 5'd12; tick();
    expect_ins("R8 xoff A", 1, OFFA);
    send(OFFA, 2'b10, 0, 0, "R10 local hold");
    tick(); tick();
    expect_ins("R10 waits for boundary despite hold", 1, OFFA);
    take();
    expect_ins("R10 taken", 0, 0);
    chk("R9 sent bit set", hold_stat[4], 1);
    rx_level = 5'd5; tick(); tick();
    expect_ins("R9 above low mark", 0, 0);
    rx_level = 5'd4; tick();
    expect_ins("R9 xon A", 1, ONA);
    take();
    chk("R9 sent bit cleared", hold_stat[4], 0);
    send(ONA, 2'b10, 0, 0, "R3 release");

    // pair sequence
    flow_mode = 4'b1100; rx_level = 5'd20; tick();
    expect_ins("R8 seq first", 1, OFFA);
    take();
    expect_ins("R8 seq second", 1, OFFB);
    chk("R9 not yet sent", hold_stat[4], 0);
    take();
    chk("R9 sent after pair", hold_stat[4], 1);
    expect_ins("R8 seq done", 0, 0);
    rx_level = 5'd0; tick();
    expect_ins("R9 seq xon first", 1, ONA);
    take();
    expect_ins("R9 seq xon second", 1, ONB);
    take();
    chk("R9 seq cleared", hold_stat[4], 0);

    // pair B
    flow_mode = 4'b0100; rx_level = 5'd31; tick();
    expect_ins("R8 xoff B", 1, OFFB);
    take();
    rx_level = 5'd1; tick();
    expect_ins("R9 xon B", 1, ONB);
    take();

    // transmit disabled
    flow_mode = 4'b0000; rx_level = 5'd25; tick(); tick();
    expect_ins("R10 tx mode off", 0, 0);
    chk("R10 no sent bit", hold_stat[4], 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule